// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This unit feeds a CPU instruction decoder with 16-bit instruction halfwords. It runs ahead of the decoder and asks an external memory for sequential 32-bit words, one request at a time over a request/ready handshake. Each returned word lands in a four-entry queue. The decoder reads the queue one halfword at a time: the lower half of a word comes first, then the upper half. Instruction fetches use their own bus, separate from data accesses.

Addresses inside a configurable internal ROM window never go through the queue. While the fetch address lies in that window, the unit drives the ROM word address combinationally and passes the selected halfword of the ROM data straight to the decoder in the same cycle. Prefetch does not issue external requests for ROM-window addresses. When sequential fetch leaves the window, prefetch resumes at the first word after its end.

A redirect (taken branch or exception) flushes the queue and restarts prefetch at the target word. A target on an odd halfword begins delivery with the upper half of its word. If an external fill is still in flight at the time of the redirect, it is marked stale and discarded when it returns.

Top module: `ifqUnit`

## Requirements
- R1: After reset the fetch address is RESET_ADDR. The decoder sees no valid instruction, and a request for the word at RESET_ADDR is presented on the external port.
- R2: Each accepted external request asks for the word 4 bytes above the previously requested word. Only one request is outstanding at a time.
- R3: The queue holds at most four words. With the decoder stalled, exactly four words are requested and then requests stop.
- R4: Queue words are delivered as halfwords, bits [15:0] first and then bits [31:16]. The delivered address rises by 2 with each accepted halfword.
- R5: While the fetch address lies in [ROM_BASE, ROM_BASE + 4*ROM_WORDS), the instruction is valid in the same cycle. Its data is the halfword of romRdata selected by address bit 1, taken from the word at romAddr. No external request ever carries a ROM-window address.
- R6: A redirect blocks delivery in its own cycle and flushes the queue. In the next cycle the instruction is valid only if the target lies in the ROM window. The first request after the redirect is for the target word, or for the first word past the ROM window if the target is inside it.
- R7: A redirect to an address with bit 1 set starts delivery from bits [31:16] of that word, at the target address with bit 0 cleared.
- R8: A fill that returns after a redirect, for a request accepted before it, is never delivered.
- R9: While instValid is high and instReady is low, instAddr and instData hold their values into the next cycle. With no word queued outside the ROM window, instValid is low.
- R10: When sequential fetch reaches the ROM window, prefetch stops at its start. Delivery continues from ROM, and the next external request is for the first word after the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| redirValid | input | 1 | Redirect strobe (branch or exception) |
| redirAddr | input | 32 | Redirect target byte address |
| instValid | output | 1 | Halfword available to decoder |
| instReady | input | 1 | Decoder accepts the halfword |
| instData | output | 16 | Instruction halfword |
| instAddr | output | 32 | Byte address of instData |
| extReqValid | output | 1 | External word request |
| extReqReady | input | 1 | External memory accepts request |
| extReqAddr | output | 32 | Word-aligned request address |
| extRespValid | input | 1 | External fill word returns |
| extRespData | input | 32 | External fill word |
| romAddr | output | 32 | Word-aligned internal ROM address |
| romRdata | input | 32 | Internal ROM word (combinational) |

## Verification
Each halfword in the bench memories encodes its own address. A wrong queue pointer, a stale fill that was kept, or a halfword select that went wrong therefore shows up as a data mismatch at the first delivery that reads the bad entry, which is at most four words after the fault. A drifting prefetch address is caught at the next accepted request, since every request address is predicted from the previous one and from the ROM window bounds. An occupancy counter that slips shows up within one stalled window, as a fifth request or as a delivery before a fill has arrived.

// File: rtl/ifqPkg.sv
package ifqPkg;
  localparam int ADDR_W    = 32;
  localparam int WORD_W    = 32;
  localparam int HALF_W    = 16;
  localparam int IFQ_DEPTH = 4;
  localparam int IFQ_PTR_W = $clog2(IFQ_DEPTH);
  localparam int IFQ_CNT_W = IFQ_PTR_W + 1;

  // strobes from control to datapath
  typedef struct packed {
    logic                 push;
    logic [IFQ_PTR_W-1:0] wrPtr;
    logic [IFQ_PTR_W-1:0] rdPtr;
    logic                 selUpper;
    logic                 romMode;
  } ifqStrobe_t;
endpackage

// File: rtl/ifqData.sv
module ifqData
  import ifqPkg::*;
(
  input  logic              clk,
  input  ifqStrobe_t        stb,
  input  logic [WORD_W-1:0] fillData,
  input  logic [WORD_W-1:0] romRdata,
  output logic [HALF_W-1:0] instData
);
  logic [WORD_W-1:0] qMem [IFQ_DEPTH];
  logic [WORD_W-1:0] srcWord;

  always_ff @(posedge clk) begin
    if (stb.push) qMem[stb.wrPtr] <= fillData;
  end

  always_comb begin
    srcWord  = stb.romMode ? romRdata : qMem[stb.rdPtr];
    instData = stb.selUpper ? srcWord[WORD_W-1:HALF_W] : srcWord[HALF_W-1:0];
  end
endmodule

// File: rtl/ifqCtrl.sv
module ifqCtrl
  import ifqPkg::*;
#(
  parameter logic [ADDR_W-1:0] ROM_BASE   = '0,
  parameter int                ROM_WORDS  = 4096,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              redirValid,
  input  logic [ADDR_W-1:0] redirAddr,
  input  logic              instReady,
  output logic              instValid,
  output logic [ADDR_W-1:0] instAddr,
  output logic              extReqValid,
  input  logic              extReqReady,
  output logic [ADDR_W-1:0] extReqAddr,
  input  logic              extRespValid,
  output logic [ADDR_W-1:0] romAddr,
  output ifqStrobe_t        stb
);
  localparam logic [ADDR_W-1:0]    ROM_BYTES = ADDR_W'(ROM_WORDS * 4);
  localparam logic [ADDR_W-1:0]    WORD_STEP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0]    HALF_STEP = ADDR_W'(2);
  localparam logic [IFQ_CNT_W-1:0] FULL_CNT  = IFQ_CNT_W'(IFQ_DEPTH);

  function automatic logic inRom(input logic [ADDR_W-1:0] a);
    return (a - ROM_BASE) < ROM_BYTES;
  endfunction

  logic [ADDR_W-1:0]    pc, pfAddr;
  logic [IFQ_CNT_W-1:0] count, countNext;
  logic [IFQ_PTR_W-1:0] rdPtr, wrPtr;
  logic                 pending, stale;
  logic                 romMode, fire, popWord, push, accept, respTake;

  always_comb begin
    romMode     = inRom(pc);
    instValid   = !redirValid && (romMode || (count != '0));
    fire        = instValid && instReady;
    popWord     = fire && pc[1] && !romMode;
    respTake    = extRespValid && pending;
    push        = respTake && !stale && !redirValid;
    extReqValid = !redirValid && !pending && !inRom(pfAddr) && (count < FULL_CNT);
    accept      = extReqValid && extReqReady;
    extReqAddr  = pfAddr;
    instAddr    = pc;
    romAddr     = pc & ~ADDR_W'(3);
    stb.push     = push;
    stb.wrPtr    = wrPtr;
    stb.rdPtr    = rdPtr;
    stb.selUpper = pc[1];
    stb.romMode  = romMode;
    unique case ({push, popWord})
      2'b10:   countNext = count + 1'b1;
      2'b01:   countNext = count - 1'b1;
      default: countNext = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= RESET_ADDR & ~ADDR_W'(1);
      pfAddr  <= RESET_ADDR & ~ADDR_W'(3);
      count   <= '0;
      rdPtr   <= '0;
      wrPtr   <= '0;
      pending <= 1'b0;
      stale   <= 1'b0;
    end else if (redirValid) begin
      pc      <= redirAddr & ~ADDR_W'(1);
      pfAddr  <= redirAddr & ~ADDR_W'(3);
      count   <= '0;
      rdPtr   <= '0;
      wrPtr   <= '0;
      pending <= pending && !respTake;
      stale   <= pending && !respTake;
    end else begin
      count <= countNext;
      if (push)    wrPtr <= wrPtr + 1'b1;
      if (popWord) rdPtr <= rdPtr + 1'b1;
      if (fire)    pc <= pc + HALF_STEP;
      if (accept) begin
        pending <= 1'b1;
        pfAddr  <= pfAddr + WORD_STEP;
      end else begin
        if (respTake) begin
          pending <= 1'b0;
          stale   <= 1'b0;
        end
        if (romMode && fire && pc[1]) pfAddr <= pfAddr + WORD_STEP;
      end
    end
  end

  // R3: queue occupancy never exceeds its depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R5: while fetching from ROM nothing sits in the queue
  p_rom_queue_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    romMode |-> (count == '0));

  // R2: no second request while one is in flight
  p_single_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    (extReqValid && extReqReady) |=> !extReqValid);

  // R6: redirect empties the queue
  p_flush_r6: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |=> (count == '0));

  // R7: delivery restarts at the target halfword
  p_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |=> (instAddr == ($past(redirAddr) & ~ADDR_W'(1))));

  // R8: a stale fill never adds a queue entry
  p_stale_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stale && extRespValid && !redirValid) |=> (count <= $past(count)));

  // R9: a stalled halfword holds its address
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !instReady && !redirValid) |=> $stable(instAddr));
endmodule

// File: rtl/ifqUnit.sv
module ifqUnit
  import ifqPkg::*;
#(
  parameter logic [31:0] ROM_BASE   = 32'h0000_0000,
  parameter int          ROM_WORDS  = 4096,
  parameter logic [31:0] RESET_ADDR = 32'h0001_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        redirValid,
  input  logic [31:0] redirAddr,
  output logic        instValid,
  input  logic        instReady,
  output logic [15:0] instData,
  output logic [31:0] instAddr,
  output logic        extReqValid,
  input  logic        extReqReady,
  output logic [31:0] extReqAddr,
  input  logic        extRespValid,
  input  logic [31:0] extRespData,
  output logic [31:0] romAddr,
  input  logic [31:0] romRdata
);
  ifqStrobe_t stb;

  ifqCtrl #(
    .ROM_BASE  (ROM_BASE),
    .ROM_WORDS (ROM_WORDS),
    .RESET_ADDR(RESET_ADDR)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .redirValid  (redirValid),
    .redirAddr   (redirAddr),
    .instReady   (instReady),
    .instValid   (instValid),
    .instAddr    (instAddr),
    .extReqValid (extReqValid),
    .extReqReady (extReqReady),
    .extReqAddr  (extReqAddr),
    .extRespValid(extRespValid),
    .romAddr     (romAddr),
    .stb         (stb)
  );

  ifqData data_i (
    .clk     (clk),
    .stb     (stb),
    .fillData(extRespData),
    .romRdata(romRdata),
    .instData(instData)
  );
endmodule

// File: tb/ifqUnit_tb_top.sv
module ifqUnit_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] ROM_LO     = 32'h100;
  localparam int          ROM_N      = 16;
  localparam logic [31:0] ROM_HI     = ROM_LO + 32'(ROM_N * 4);
  localparam logic [31:0] RST_PC     = 32'h200;

  logic clk = 0, rstN = 0, redirValid = 0, instReady = 0;
  logic extReqReady = 0, extRespValid = 0;
  logic [31:0] redirAddr = '0, extRespData = '0;
  logic instValid, extReqValid;
  logic [15:0] instData;
  logic [31:0] instAddr, extReqAddr, romAddr, romRdata;

  int nChecks = 0, nErrors = 0;

  function automatic logic [15:0] extHw(input logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction
  function automatic logic [15:0] romHw(input logic [31:0] a);
    return a[15:0] + 16'h6100;
  endfunction
  function automatic logic inRomB(input logic [31:0] a);
    return (a >= ROM_LO) && (a < ROM_HI);
  endfunction
  function automatic logic [31:0] firstReq(input logic [31:0] a);
    return inRomB(a & ~32'h3) ? ROM_HI : (a & ~32'h3);
  endfunction

  assign romRdata = {romHw(romAddr + 32'd2), romHw(romAddr)};

  always #(CLK_PERIOD/2) clk = ~clk;

  ifqUnit #(.ROM_BASE(ROM_LO), .ROM_WORDS(ROM_N), .RESET_ADDR(RST_PC)) dut_i (
    .clk(clk), .rstN(rstN), .redirValid(redirValid), .redirAddr(redirAddr),
    .instValid(instValid), .instReady(instReady), .instData(instData),
    .instAddr(instAddr), .extReqValid(extReqValid), .extReqReady(extReqReady),
    .extReqAddr(extReqAddr), .extRespValid(extRespValid), .extRespData(extRespData),
    .romAddr(romAddr), .romRdata(romRdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench state
  int cyc = 0, lat = 0, rdyMod = 1, irdyMod = 1, acceptCnt = 0;
  bit forceStall = 0;
  bit memBusy = 0, memStale = 0, staleSeg = 0;
  int memCnt = 0;
  logic [31:0] memAddr = '0;
  logic [31:0] expPc = RST_PC, expReq = RST_PC, lastTgt = '0;
  bit firstReqPending = 1, firstDel = 1, haveLast = 0, lastInRom = 0, skipNext = 0;
  bit redirCheck = 0, prevHeld = 0;
  logic [31:0] prevAddr = '0;
  logic [15:0] prevData = '0;

  task automatic step(input bit doRedir, input logic [31:0] tgt);
    string tag;
    logic [15:0] eHw;
    @(negedge clk);
    cyc++;
    if (prevHeld) begin
      chk(instAddr == prevAddr, "R9 held address", instAddr, prevAddr);
      chk(instData == prevData, "R9 held data", {16'h0, instData}, {16'h0, prevData});
    end
    extRespValid = 0;
    if (memBusy) begin
      if (memCnt == 0) begin
        extRespValid = 1;
        extRespData  = {extHw(memAddr + 32'd2), extHw(memAddr)};
        memBusy = 0;
        if (memStale) staleSeg = 1;
        memStale = 0;
      end else memCnt--;
    end
    extReqReady = (rdyMod == 1) ? 1'b1 : ((cyc % rdyMod) != 0);
    instReady   = forceStall ? 1'b0 : ((irdyMod == 1) ? 1'b1 : ((cyc % irdyMod) != 0));
    redirValid  = doRedir;
    redirAddr   = tgt;
    #1;
    if (redirCheck && !doRedir) begin
      chk(instValid == inRomB(lastTgt), "R6 valid after redirect", {31'h0, instValid}, {31'h0, inRomB(lastTgt)});
      chk(instAddr == (lastTgt & ~32'h1), "R7 restart address", instAddr, lastTgt & ~32'h1);
    end
    redirCheck = 0;
    if (doRedir) chk(instValid == 1'b0, "R6 blocked in redirect cycle", {31'h0, instValid}, 32'h0);
    if (extReqValid && extReqReady) begin
      tag = firstReqPending ? "R6 first request" : (skipNext ? "R10 skip window" : "R2 sequential");
      chk(extReqAddr == expReq, tag, extReqAddr, expReq);
      chk(!inRomB(extReqAddr), "R5 no ROM request", extReqAddr, ROM_HI);
      skipNext = inRomB(extReqAddr + 32'd4);
      expReq   = skipNext ? ROM_HI : extReqAddr + 32'd4;
      firstReqPending = 0;
      memBusy = 1; memCnt = lat; memAddr = extReqAddr;
      acceptCnt++;
    end
    if (instValid && instReady && !doRedir) begin
      eHw = inRomB(expPc) ? romHw(expPc) : extHw(expPc);
      tag = "R4 halfword order";
      if (staleSeg) tag = "R8 stale dropped";
      if (inRomB(expPc)) tag = "R5 ROM bypass";
      if (firstDel && expPc[1]) tag = "R7 upper first";
      if (haveLast && (lastInRom != inRomB(expPc))) tag = "R10 region crossing";
      chk(instAddr == expPc, tag, instAddr, expPc);
      chk(instData == eHw, tag, {16'h0, instData}, {16'h0, eHw});
      lastInRom = inRomB(expPc);
      haveLast = 1; firstDel = 0;
      expPc = expPc + 32'd2;
    end
    prevHeld = instValid && !instReady && !doRedir;
    prevAddr = instAddr;
    prevData = instData;
    if (doRedir) begin
      if (memBusy) memStale = 1;
      staleSeg = 0;
      expPc = tgt & ~32'h1;
      expReq = firstReq(tgt);
      skipNext = inRomB(tgt);
      firstReqPending = 1; firstDel = 1; haveLast = 0;
      lastTgt = tgt; redirCheck = 1;
    end
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [31:0] targets [8];
    targets = '{32'h0F8, 32'h0FA, 32'h13C, 32'h13E, 32'h102, 32'h300, 32'h306, 32'h1FE};
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(instValid == 1'b0, "R1 reset valid", {31'h0, instValid}, 32'h0);
    rstN = 1;
    #1;
    chk(instValid == 1'b0, "R1 idle after reset", {31'h0, instValid}, 32'h0);
    chk(extReqValid == 1'b1, "R1 first request", {31'h0, extReqValid}, 32'h1);
    chk(extReqAddr == RST_PC, "R1 request address", extReqAddr, RST_PC);
    chk(instAddr == RST_PC, "R1 fetch address", instAddr, RST_PC);
    repeat (30) step(0, '0);

    // R3: decoder stalled, exactly four words requested
    forceStall = 1; lat = 0; rdyMod = 1; irdyMod = 1;
    step(1, 32'h400);
    acceptCnt = 0;
    repeat (25) step(0, '0);
    chk(acceptCnt == 4, "R3 queue capacity", acceptCnt, 4);
    forceStall = 0;
    repeat (30) step(0, '0);

    for (int l = 0; l < 4; l++)
      for (int r = 1; r <= 3; r++)
        for (int d = 1; d <= 3; d++)
          for (int t = 0; t < 8; t++) begin
            lat = l; rdyMod = r; irdyMod = d;
            step(1, targets[t]);
            repeat (59) step(0, '0);
          end

    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule